// File: doc/BRIEF.md
# Test-and-Set Lock Word with Ownership Directory

This block holds a single lock word that a group of cores contend for with atomic test-and-set operations and release stores. A small directory beside the word records whether any cache currently holds the lock's line and, if so, which core. Every operation needs the line in exclusive form. The directory therefore decides, for each served operation, whether an invalidation has to go to the previous holder. It then hands the line to the requester.

Each core drives its own request bit and opcode. A fixed-priority picker serves one request per cycle, and the lowest-numbered core wins. A granted core sees its grant bit in the same cycle and drops its request afterwards. One cycle later the block returns the lock value that stood before the operation, together with the number of invalidations it caused (zero or one). A saturating counter accumulates every invalidation sent since reset.

Top module: `tas_lock_dir_top`

## Requirements
- R1: After reset the lock word is 0, no core holds the line, no response is valid and the invalidation total is 0.
- R2: A served test-and-set (opcode bit 0) leaves the lock word at 1 and returns the value the word held just before it.
- R3: A served release (opcode bit 1) leaves the lock word at 0 and returns the value the word held just before it.
- R4: An operation served while no core holds the line sends zero invalidations.
- R5: An operation by a core other than the current holder sends exactly one invalidation, and the requester becomes the holder.
- R6: An operation by the core that already holds the line sends zero invalidations.
- R7: The invalidation total adds each response's count and stops at its all-ones value, 2^CNT_W-1.
- R8: At most one grant is raised per cycle, only to a requesting core. Among the cores requesting in a cycle, the lowest-numbered one is granted.
- R9: The response is valid in the cycle after the grant and carries the granted core's number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | N_CORES | Per-core request, held until granted |
| req_op | input | N_CORES | Per-core opcode: 0 test-and-set, 1 release |
| req_gnt | output | N_CORES | One-hot grant, same cycle as the request it serves |
| rsp_vld | output | 1 | Response valid |
| rsp_core | output | $clog2(N_CORES) | Core the response belongs to |
| rsp_old | output | 1 | Lock value before the operation |
| rsp_inv | output | 1 | Invalidations sent by the operation |
| inv_total | output | CNT_W | Saturating invalidation total |
| lock_word | output | 1 | Current lock value |
| holder_vld | output | 1 | Some core holds the line |
| holder_core | output | $clog2(N_CORES) | Core holding the line |

## Verification
The bench builds the block with four cores and a 4-bit total. With four cores, every ordered sequence of three operations over all cores and both opcodes can be enumerated in full, 512 sequences, each starting from reset. Those sequences reach first access, same-holder repeats, holder changes and releases in every order. The narrow total saturates after fifteen invalidations, so a short spin loop reaches the cap. A simultaneous burst from three cores exercises the priority order and the one-per-cycle serving.

// File: rtl/tas_lock_pkg.sv
package tas_lock_pkg;
    typedef enum logic {
        OP_TAS = 1'b0,
        OP_REL = 1'b1
    } lock_op_e;
endpackage

// File: rtl/tas_lock_arb.sv
module tas_lock_arb #(
    parameter int N_CORES = 4,
    localparam int IDW = $clog2(N_CORES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] req,
    output logic [N_CORES-1:0] gnt,
    output logic               gnt_vld,
    output logic [IDW-1:0]     gnt_id
);
    always_comb begin
        gnt     = '0;
        gnt_vld = 1'b0;
        gnt_id  = '0;
        for (int i = N_CORES - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt     = '0;
                gnt[i]  = 1'b1;
                gnt_vld = 1'b1;
                gnt_id  = IDW'(i);
            end
        end
    end

    // R8
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && ((gnt & ~req) == '0));

    // R8
    gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld |-> ((req & (gnt - 1'b1)) == '0));
endmodule

// File: rtl/tas_lock_dir.sv
module tas_lock_dir
    import tas_lock_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 32,
    localparam int IDW = $clog2(N_CORES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srv_vld,
    input  logic [IDW-1:0]   srv_id,
    input  lock_op_e         srv_op,
    output logic             rsp_vld,
    output logic [IDW-1:0]   rsp_core,
    output logic             rsp_old,
    output logic             rsp_inv,
    output logic [CNT_W-1:0] inv_total,
    output logic             lock_word,
    output logic             holder_vld,
    output logic [IDW-1:0]   holder_core
);
    localparam logic [CNT_W-1:0] TOTAL_MAX = '1;

    typedef struct packed {
        logic             lock;
        logic             hvld;
        logic [IDW-1:0]   hid;
        logic             rvld;
        logic [IDW-1:0]   rid;
        logic             rold;
        logic             rinv;
        logic [CNT_W-1:0] total;
    } dir_state_t;

    dir_state_t st_d, st_q;
    logic       need_inv;

    always_comb begin
        st_d      = st_q;
        need_inv  = st_q.hvld && (st_q.hid != srv_id);
        st_d.rvld = srv_vld;
        if (srv_vld) begin
            st_d.rid  = srv_id;
            st_d.rold = st_q.lock;
            st_d.rinv = need_inv;
            st_d.lock = (srv_op == OP_TAS);
            st_d.hvld = 1'b1;
            st_d.hid  = srv_id;
            if (need_inv && st_q.total != TOTAL_MAX)
                st_d.total = st_q.total + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_vld     = st_q.rvld;
    assign rsp_core    = st_q.rid;
    assign rsp_old     = st_q.rold;
    assign rsp_inv     = st_q.rinv;
    assign inv_total   = st_q.total;
    assign lock_word   = st_q.lock;
    assign holder_vld  = st_q.hvld;
    assign holder_core = st_q.hid;

    // R2
    tas_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_vld && srv_op == OP_TAS) |=> (lock_word && rsp_old == $past(lock_word)));

    // R3
    rel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_vld && srv_op == OP_REL) |=> (!lock_word && rsp_old == $past(lock_word)));

    // R4
    cold_no_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_vld && !holder_vld) |=> !rsp_inv);

    // R5
    new_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srv_vld |=> (holder_vld && holder_core == rsp_core));

    // R6
    same_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_vld && holder_vld && holder_core == srv_id) |=> !rsp_inv);

    // R7
    total_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (inv_total >= $past(inv_total)));

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld == $past(srv_vld));
endmodule

// File: rtl/tas_lock_dir_top.sv
module tas_lock_dir_top
    import tas_lock_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int CNT_W   = 32,
    localparam int IDW = $clog2(N_CORES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] req_vld,
    input  logic [N_CORES-1:0] req_op,
    output logic [N_CORES-1:0] req_gnt,
    output logic               rsp_vld,
    output logic [IDW-1:0]     rsp_core,
    output logic               rsp_old,
    output logic               rsp_inv,
    output logic [CNT_W-1:0]   inv_total,
    output logic               lock_word,
    output logic               holder_vld,
    output logic [IDW-1:0]     holder_core
);
    logic           pick_vld;
    logic [IDW-1:0] pick_id;
    lock_op_e       pick_op;

    tas_lock_arb #(.N_CORES(N_CORES)) arb_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_vld),
        .gnt     (req_gnt),
        .gnt_vld (pick_vld),
        .gnt_id  (pick_id)
    );

    assign pick_op = lock_op_e'(req_op[pick_id]);

    tas_lock_dir #(.N_CORES(N_CORES), .CNT_W(CNT_W)) dir_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .srv_vld     (pick_vld),
        .srv_id      (pick_id),
        .srv_op      (pick_op),
        .rsp_vld     (rsp_vld),
        .rsp_core    (rsp_core),
        .rsp_old     (rsp_old),
        .rsp_inv     (rsp_inv),
        .inv_total   (inv_total),
        .lock_word   (lock_word),
        .holder_vld  (holder_vld),
        .holder_core (holder_core)
    );
endmodule

// File: tb/tas_lock_dir_tb.sv
`timescale 1ns/1ps
module tas_lock_dir_top_tb_top;
    localparam int NC  = 4;
    localparam int CW  = 4;
    localparam int IDW = 2;
    localparam int MAXT = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] req_vld = '0;
    logic [NC-1:0] req_op = '0;
    logic [NC-1:0] req_gnt;
    logic          rsp_vld, rsp_old, rsp_inv, lock_word, holder_vld;
    logic [IDW-1:0] rsp_core, holder_core;
    logic [CW-1:0] inv_total;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int m_lock, m_hvld, m_hid, m_total;

    always #4 clk = ~clk;

    tas_lock_dir_top #(.N_CORES(NC), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_op(req_op),
        .req_gnt(req_gnt), .rsp_vld(rsp_vld), .rsp_core(rsp_core),
        .rsp_old(rsp_old), .rsp_inv(rsp_inv), .inv_total(inv_total),
        .lock_word(lock_word), .holder_vld(holder_vld), .holder_core(holder_core)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_vld = '0;
        @(negedge clk);
        rst_n = 1'b1;
        m_lock = 0; m_hvld = 0; m_hid = 0; m_total = 0;
    endtask

    task automatic do_op(input int core, input int op, input bit full);
        int exp_inv, exp_old;
        @(negedge clk);
        req_vld = '0;
        req_vld[core] = 1'b1;
        req_op[core]  = op[0];
        #1;
        if (full) chk(req_gnt == NC'(1 << core), "R8 grant", int'(req_gnt), 1 << core);
        exp_inv = (m_hvld != 0 && m_hid != core) ? 1 : 0;
        exp_old = m_lock;
        m_lock  = (op == 0) ? 1 : 0;
        m_hvld  = 1; m_hid = core;
        if (exp_inv == 1 && m_total < MAXT) m_total++;
        @(posedge clk);
        @(negedge clk);
        req_vld = '0;
        if (full) begin
            chk(rsp_vld && rsp_core == IDW'(core), "R9 rsp core", int'(rsp_core), core);
            chk(rsp_old == exp_old[0], op == 0 ? "R2 old" : "R3 old", int'(rsp_old), exp_old);
            chk(lock_word == m_lock[0], op == 0 ? "R2 word" : "R3 word", int'(lock_word), m_lock);
        end
        chk(rsp_inv == exp_inv[0], exp_old == 0 && exp_inv == 0 ? "R4/R6 inv" : "R5 inv",
            int'(rsp_inv), exp_inv);
        chk(int'(inv_total) == m_total, "R7 total", int'(inv_total), m_total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        // R1
        chk(!lock_word && !holder_vld && !rsp_vld && inv_total == 0, "R1 reset",
            int'(inv_total), 0);

        // R4 R5 R6 R2 R3: every ordered three-step sequence
        for (int s = 0; s < 512; s++) begin
            do_reset();
            for (int k = 0; k < 3; k++) begin
                int code = (s >> (3 * k)) & 7;
                do_op(code >> 1, code & 1, (s % 8) == 0 || k == 2);
            end
            chk(holder_vld && int'(holder_core) == m_hid, "R5 holder", int'(holder_core), m_hid);
        end

        // R5: four first-time attempts give three invalidations
        do_reset();
        for (int c = 0; c < NC; c++) do_op(c, 0, 1'b1);
        chk(int'(inv_total) == NC - 1, "R5 first round", int'(inv_total), NC - 1);

        // R7: spin between two cores until the total saturates
        do_reset();
        for (int k = 0; k < 20; k++) do_op(k & 1, 0, 1'b0);
        chk(int'(inv_total) == MAXT, "R7 saturate", int'(inv_total), MAXT);
        do_op(0, 1, 1'b1);

        // R8: simultaneous burst from cores 0, 1 and 3
        do_reset();
        @(negedge clk);
        req_op  = '0;
        req_vld = 4'b1011;
        #1;
        chk(req_gnt == 4'b0001, "R8 pick0", int'(req_gnt), 1);
        @(negedge clk);
        chk(rsp_vld && rsp_core == 0 && rsp_inv == 0, "R9 burst0", int'(rsp_core), 0);
        req_vld[0] = 1'b0;
        #1;
        chk(req_gnt == 4'b0010, "R8 pick1", int'(req_gnt), 2);
        @(negedge clk);
        chk(rsp_core == 1 && rsp_inv && rsp_old, "R5 burst1", int'(rsp_core), 1);
        req_vld[1] = 1'b0;
        #1;
        chk(req_gnt == 4'b1000, "R8 pick3", int'(req_gnt), 8);
        @(negedge clk);
        chk(rsp_core == 3 && rsp_inv && rsp_old, "R5 burst3", int'(rsp_core), 3);
        req_vld = '0;
        chk(int'(inv_total) == 2, "R7 burst total", int'(inv_total), 2);
        @(negedge clk);
        chk(!rsp_vld, "R9 idle", int'(rsp_vld), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule